// File: doc/BRIEF.md
# Circuit Genotype Active-Node Marker

This block holds one candidate transistor-level circuit in its grid encoding and works out which grid nodes take part in the circuit that the encoding describes. Each node has a kind (p-type transistor, n-type transistor or junction) and two source labels. A separate list of output labels says where the circuit outputs are taken from. Software or a search engine fills the storage through a simple load port, pulses `start`, and waits for `done`. The block then presents a per-node activity vector, the number of active nodes, how many of them are junctions and how many are transistors, and a flag for any label that breaks the encoding rules.

Label numbering puts the primary inputs first (indices 0 and 1 being the two supply rails) and the node outputs after them. Node `i` sits in column `i / N_ROW` and its output carries label `N_IN + i`. A transistor source may also be a negative label that stands for an inverted primary input. A source that names a node must point at one of the `LBACK` columns immediately to the left. Because every link points backwards, the marking needs only a seeding step, one descending pass over the nodes and one ascending pass.

Top module: `gene_activity_marker`

## Requirements
- R1: With `ld_en` high while the block is idle, `ld_out`=0 writes kind `ld_kind` (0 = p-type, 1 = n-type, 2 = junction, 3 = reserved) and sources `ld_src_a`/`ld_src_b` to node `ld_addr`, and `ld_out`=1 writes `ld_src_a` as output label `ld_addr`. A load presented during a marking run has no effect.
- R2: An output label equal to `N_IN + i` makes node `i` active. An output label below `N_IN` activates no node.
- R3: In the descending pass, an active node activates every node named by one of its legal node-valued source labels, whatever that node's kind.
- R4: Source labels 0 to `N_IN-1` and inverted labels from `-(N_IN-1)` to `-2` never activate a node.
- R5: In the ascending pass that follows, an inactive junction becomes active when a legal node-valued source of it is active. Nodes are visited in increasing order, so a junction can activate a later junction.
- R6: `done` is high for exactly one cycle, after the `2*NN+1`-th rising edge that follows the edge at which `start` was sampled in idle. A `start` pulse during a run is ignored.
- R7: When `done` is high, `n_active` equals the number of set bits of `active`. `n_junc` counts the active nodes of kind 2 and `n_trans` counts the active nodes of kind 0 or 1.
- R8: While idle and with no `start`, `active`, the counts and `enc_err` hold their values, including while the storage is reloaded.
- R9: `enc_err` is set at `done` if any node has kind 3, or if any node has a source that is neither a node label from columns `c-LBACK` to `c-1` (where `c` is the node's column) nor, for a transistor, a primary or inverted input label, or if any output label lies outside 0 to `N_IN+NN-1`. Illegal sources never activate a node.
- R10: After reset, `done`, `active`, all counts and `enc_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe |
| ld_out | input | 1 | 1 selects an output label, 0 selects a node |
| ld_addr | input | AW | Node index or output index |
| ld_src_a | input | LW | First source label (signed), or the output label |
| ld_src_b | input | LW | Second source label (signed) |
| ld_kind | input | 2 | Node kind |
| start | input | 1 | Begin a marking run |
| done | output | 1 | One-cycle completion pulse |
| active | output | NN | Per-node activity, bit i for node i |
| n_active | output | CW | Active node count |
| n_junc | output | CW | Active junction count |
| n_trans | output | CW | Active transistor count |
| enc_err | output | 1 | Encoding violation seen during the run |

## Verification
The bench uses 4 inputs (two rails and two signals), a 4-by-2 grid, 2 outputs and a lookback of 2 columns. With a lookback of 2 on a 4-column grid, the column-3 nodes have a window that excludes column 0, so a source that reaches past the window can be exercised. Two inputs are enough to produce both inverted labels and labels that name a rail. The grid is small enough that the `done` timing is compared on every cycle of every run, and randomly drawn genomes of mixed kinds reach junction chains, junctions in column 0 with no legal node source, and output labels that name primary inputs.

// File: rtl/gene_activity_marker.sv
module gene_activity_marker #(
  parameter int N_IN  = 4,
  parameter int N_COL = 4,
  parameter int N_ROW = 2,
  parameter int N_OUT = 2,
  parameter int LBACK = 2,
  parameter int NN    = N_COL * N_ROW,
  parameter int LW    = $clog2(N_IN + NN) + 1,
  parameter int AW    = (NN > N_OUT) ? $clog2(NN) : $clog2(N_OUT + 1),
  parameter int CW    = $clog2(NN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_en,
  input  logic                 ld_out,
  input  logic [AW-1:0]        ld_addr,
  input  logic signed [LW-1:0] ld_src_a,
  input  logic signed [LW-1:0] ld_src_b,
  input  logic [1:0]           ld_kind,
  input  logic                 start,
  output logic                 done,
  output logic [NN-1:0]        active,
  output logic [CW-1:0]        n_active,
  output logic [CW-1:0]        n_junc,
  output logic [CW-1:0]        n_trans,
  output logic                 enc_err
);
  localparam int NL = N_IN + NN;
  localparam int IW = $clog2(NN);

  typedef enum logic [1:0] {S_IDLE, S_SEED, S_REV, S_FWD} st_t;
  st_t st;
  logic [IW-1:0] idx;

  logic signed [LW-1:0] src_a [NN];
  logic signed [LW-1:0] src_b [NN];
  logic [1:0]           kind  [NN];
  logic signed [LW-1:0] olab  [N_OUT];

  function automatic logic node_ok(input int i, input int x);
    int c, lo;
    c  = i / N_ROW;
    lo = (c - LBACK) * N_ROW;
    if (lo < 0) lo = 0;
    return (x >= N_IN + lo) && (x < N_IN + c * N_ROW);
  endfunction

  function automatic logic src_ok(input int i, input int x, input logic [1:0] k);
    return node_ok(i, x) ||
           (k < 2'd2 && ((x >= 0 && x < N_IN) || (x <= -2 && x >= 1 - N_IN)));
  endfunction

  always_ff @(posedge clk) begin
    if (ld_en && st == S_IDLE) begin
      if (ld_out) begin
        if (int'(ld_addr) < N_OUT) olab[ld_addr] <= ld_src_a;
      end else if (int'(ld_addr) < NN) begin
        src_a[ld_addr] <= ld_src_a;
        src_b[ld_addr] <= ld_src_b;
        kind[ld_addr]  <= ld_kind;
      end
    end
  end

  logic [NN-1:0] seedv, mark;
  logic          out_bad, junc_hit, bad, is_junc, hit;

  always_comb begin
    seedv   = '0;
    out_bad = 1'b0;
    for (int o = 0; o < N_OUT; o++) begin
      if (int'(olab[o]) < 0 || int'(olab[o]) >= NL) out_bad = 1'b1;
      for (int j = 0; j < NN; j++)
        if (int'(olab[o]) == N_IN + j) seedv[j] = 1'b1;
    end
  end

  always_comb begin
    int i, xa, xb;
    logic oka, okb;
    i   = int'(idx);
    xa  = int'(src_a[idx]);
    xb  = int'(src_b[idx]);
    oka = node_ok(i, xa);
    okb = node_ok(i, xb);
    mark     = '0;
    junc_hit = 1'b0;
    for (int j = 0; j < NN; j++) begin
      if ((oka && xa == N_IN + j) || (okb && xb == N_IN + j)) begin
        if (active[idx]) mark[j] = 1'b1;
        if (active[j])   junc_hit = 1'b1;
      end
    end
    bad = !src_ok(i, xa, kind[idx]) || !src_ok(i, xb, kind[idx]) || kind[idx] == 2'd3;
  end

  assign is_junc = (kind[idx] == 2'd2);
  assign hit     = active[idx] | (is_junc & junc_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      done     <= 1'b0;
      active   <= '0;
      n_active <= '0;
      n_junc   <= '0;
      n_trans  <= '0;
      enc_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) st <= S_SEED;
        S_SEED: begin
          active   <= seedv;
          enc_err  <= out_bad;
          n_active <= '0;
          n_junc   <= '0;
          n_trans  <= '0;
          idx      <= IW'(NN - 1);
          st       <= S_REV;
        end
        S_REV: begin
          active <= active | mark;
          if (idx == '0) st <= S_FWD;
          else idx <= idx - 1'b1;
        end
        S_FWD: begin
          active[idx] <= hit;
          n_active    <= n_active + CW'(hit);
          n_junc      <= n_junc + CW'(hit & is_junc);
          n_trans     <= n_trans + CW'(hit & (kind[idx] < 2'd2));
          enc_err     <= enc_err | bad;
          if (idx == IW'(NN - 1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_popcount_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> n_active == CW'($countones(active)));

  p_split_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, n_junc} + {1'b0, n_trans}) <= {1'b0, n_active});

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> ($stable(active) && $stable(n_active) && $stable(enc_err)));

  p_rev_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REV) |=> ((active & $past(active)) == $past(active)));
endmodule

// File: tb/gene_activity_marker_tb.sv
`timescale 1ns/1ps
module gene_activity_marker_tb;
  localparam int NI = 4, NC = 4, NR = 2, NO = 2, LB = 2;
  localparam int NN = NC * NR, LW = 5, AW = 3, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 1'b0, ld_out = 1'b0, start = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic signed [LW-1:0] ld_src_a = '0, ld_src_b = '0;
  logic [1:0] ld_kind = '0;
  logic done, enc_err;
  logic [NN-1:0] active;
  logic [CW-1:0] n_active, n_junc, n_trans;

  always #2.5 clk = ~clk;

  gene_activity_marker #(.N_IN(NI), .N_COL(NC), .N_ROW(NR), .N_OUT(NO), .LBACK(LB)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_out(ld_out), .ld_addr(ld_addr),
    .ld_src_a(ld_src_a), .ld_src_b(ld_src_b), .ld_kind(ld_kind), .start(start),
    .done(done), .active(active), .n_active(n_active), .n_junc(n_junc),
    .n_trans(n_trans), .enc_err(enc_err));

  int n_run = 0, n_fail = 0;
  int sa[NN], sb[NN], kd[NN], ol[NO];
  logic [NN-1:0] e_act;
  int e_n, e_j, e_t;
  bit e_err;

  task automatic chk(input bit ok, input string tag, input longint a, input longint e);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  function automatic bit m_node(int i, int x);
    int c = i / NR;
    int lo = (c - LB) * NR;
    if (lo < 0) lo = 0;
    return x >= NI + lo && x < NI + c * NR;
  endfunction

  function automatic bit m_src(int i, int x, int k);
    return m_node(i, x) || (k < 2 && ((x >= 0 && x < NI) || (x <= -2 && x >= 1 - NI)));
  endfunction

  task automatic model();
    logic [NN-1:0] v = '0;
    e_err = 0; e_n = 0; e_j = 0; e_t = 0;
    foreach (ol[o]) begin
      if (ol[o] >= NI && ol[o] < NI + NN) v[ol[o] - NI] = 1'b1;
      if (ol[o] < 0 || ol[o] >= NI + NN) e_err = 1;
    end
    for (int i = NN - 1; i >= 0; i--)
      if (v[i]) begin
        if (m_node(i, sa[i])) v[sa[i] - NI] = 1'b1;
        if (m_node(i, sb[i])) v[sb[i] - NI] = 1'b1;
      end
    for (int i = 0; i < NN; i++) begin
      if (kd[i] == 2 && ((m_node(i, sa[i]) && v[sa[i] - NI]) || (m_node(i, sb[i]) && v[sb[i] - NI])))
        v[i] = 1'b1;
      if (!m_src(i, sa[i], kd[i]) || !m_src(i, sb[i], kd[i]) || kd[i] == 3) e_err = 1;
      if (v[i]) begin
        e_n++;
        if (kd[i] == 2) e_j++;
        if (kd[i] < 2) e_t++;
      end
    end
    e_act = v;
  endtask

  task automatic put_node(int i, int k, int a, int b);
    sa[i] = a; sb[i] = b; kd[i] = k;
    ld_en = 1; ld_out = 0; ld_addr = AW'(i);
    ld_src_a = LW'(a); ld_src_b = LW'(b); ld_kind = 2'(k);
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic put_out(int o, int lab);
    ol[o] = lab;
    ld_en = 1; ld_out = 1; ld_addr = AW'(o); ld_src_a = LW'(lab);
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic compare(input string tag);
    chk(active == e_act, {tag, " R3 active"}, active, e_act);
    chk(n_active == CW'(e_n), {tag, " R7 n_active"}, n_active, e_n);
    chk(n_junc == CW'(e_j), {tag, " R7 n_junc"}, n_junc, e_j);
    chk(n_trans == CW'(e_t), {tag, " R7 n_trans"}, n_trans, e_t);
    chk(enc_err == e_err, {tag, " R9 enc_err"}, enc_err, e_err);
  endtask

  task automatic run(input string tag, input bit disturb);
    model();
    start = 1;
    @(negedge clk);
    for (int k = 0; k <= 2 * NN + 2; k++) begin
      if (k == 0) start = 0;
      chk(done == (k == 2 * NN + 1), {tag, " R6 done timing"}, done, k == 2 * NN + 1);
      if (k == 2 * NN + 1) compare(tag);
      if (disturb && k == 3) begin
        start = 1;
        ld_en = 1; ld_out = 1; ld_addr = AW'(1); ld_src_a = LW'(NI + NN - 1);
      end
      if (disturb && k == 4) begin
        start = 0; ld_en = 0;
      end
      @(negedge clk);
    end
  endtask

  task automatic rand_genome();
    for (int i = 0; i < NN; i++) begin
      int c = i / NR;
      int lo = (c - LB) * NR;
      int k = $urandom_range(0, 2);
      int s[2];
      if (lo < 0) lo = 0;
      for (int t = 0; t < 2; t++) begin
        if (c > 0 && (k == 2 || $urandom_range(0, 1) == 1))
          s[t] = NI + $urandom_range(lo, c * NR - 1);
        else begin
          int r = $urandom_range(0, 5);
          s[t] = (r < 4) ? r : -(r - 2);
        end
      end
      put_node(i, k, s[0], s[1]);
    end
    put_out(0, NI + $urandom_range(NN / 2, NN - 1));
    put_out(1, $urandom_range(0, NI + NN - 1));
  endtask

  initial begin
    logic [NN-1:0] hold_act;
    int hold_n;
    bit hold_e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: state after reset
    chk(done == 0, "R10 done", done, 0);
    chk(active == 0, "R10 active", active, 0);
    chk(n_active == 0 && n_junc == 0 && n_trans == 0, "R10 counts", n_active, 0);
    chk(enc_err == 0, "R10 enc_err", enc_err, 0);

    // Genome A: R2 (output names input 2), R4 (inverted and rail sources)
    put_node(0, 1, 2, 1);  put_node(1, 0, -3, 0);
    put_node(2, 2, 4, 5);  put_node(3, 0, -2, 3);
    put_node(4, 1, 6, 2);  put_node(5, 0, 7, 0);
    put_node(6, 2, 8, 9);  put_node(7, 1, 6, 3);
    put_out(0, 10); put_out(1, 2);
    run("R2 R4 genome A", 0);
    chk(active == 8'h7f, "R2 R4 genome A hand value", active, 8'h7f);

    // R8: reload storage while idle, results must hold
    hold_act = active; hold_n = n_active; hold_e = enc_err;
    put_node(7, 2, 8, 9); put_out(0, 11);
    repeat (3) @(negedge clk);
    chk(active == hold_act, "R8 active hold", active, hold_act);
    chk(n_active == CW'(hold_n) && enc_err == hold_e, "R8 counts hold", n_active, hold_n);

    // Genome B: R5 junction activated in the ascending pass
    put_node(0, 1, 2, 1);  put_node(1, 0, 3, 0);
    put_node(2, 2, 4, 5);  put_node(3, 1, 4, 1);
    put_node(4, 2, 6, 8);  put_node(5, 1, 2, 3);
    put_node(6, 1, 2, 3);  put_node(7, 1, 2, 3);
    put_out(0, 7); put_out(1, 0);
    run("R5 genome B", 0);
    chk(active == 8'b0001_1101, "R5 junction chain", active, 8'b0001_1101);

    // R9: source beyond lookback window does not mark
    put_node(7, 1, 5, 3); put_out(0, 11); put_out(1, 1);
    run("R9 window", 0);
    chk(active[1] == 0, "R9 illegal source no mark", active[1], 0);
    // R9: reserved kind, then bad output label
    put_node(7, 1, 6, 3); put_node(3, 3, 2, 3);
    run("R9 kind3", 0);
    put_node(3, 0, -2, 3); put_out(1, NI + NN);
    run("R9 out label", 0);

    // R1 and R6: load and start during a run are ignored
    put_node(0, 1, 2, 1);  put_node(1, 0, -3, 0);
    put_node(2, 2, 4, 5);  put_node(3, 0, -2, 3);
    put_node(4, 1, 6, 2);  put_node(5, 0, 7, 0);
    put_node(6, 2, 8, 9);  put_node(7, 1, 6, 3);
    put_out(0, 10); put_out(1, 2);
    run("R1 R6 disturbed", 1);
    run("R1 R6 rerun", 0);

    for (int g = 0; g < 8; g++) begin
      rand_genome();
      run("R3 R5 random", 0);
    end
    summary();
  end
endmodule